// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind a parallel NOR-flash style write bus. It turns multi-cycle write sequences into program operations on a small internal word array. Each cycle carries at most one bus write, made of an address, data and a write strobe.

The decoder recognises three kinds of sequence:

- Ordinary programming: two unlock writes, a setup command, then the target address and data.
- A fast bypass mode: programming takes only two writes, and the mode is left with a two-write reset.
- A secured region: while the mode is active, reads and programs go to a separate small bank.

An accelerate input puts the decoder straight into bypass mode. An accepted program holds a busy flag for a fixed, parameterised number of cycles. The write into the array happens on the last busy cycle. A program can only clear bits.

The state machine has these states:

- `S_IDLE`: read mode, or bypass idle when the bypass flag is set.
- `S_UNL1`: first unlock write seen.
- `S_UNL2`: second unlock write seen.
- `S_ADDR`: waiting for the address/data write.
- `S_BUSY`: program running.
- `S_BYP_EXIT`: bypass reset command seen, waiting for the confirm write.
- `S_SEC_EXIT`: secured exit command seen, waiting for the confirm write.

The transitions are:

- `S_IDLE`→`S_UNL1` on 0x555/0xAA (bypass flag clear).
- `S_UNL1`→`S_UNL2` on 0x2AA/0x55.
- `S_UNL1`→`S_IDLE` on any other write.
- `S_UNL2`→`S_ADDR` on 0x555/0xA0.
- `S_UNL2`→`S_IDLE` on every other write. The data decides the side effect: 0x20 sets bypass, 0x88 sets secured, 0x90 goes to `S_SEC_EXIT` when secured, and anything else has none.
- `S_IDLE`→`S_ADDR` on 0xA0 in bypass.
- `S_IDLE`→`S_BYP_EXIT` on 0x90 in bypass.
- `S_BYP_EXIT`/`S_SEC_EXIT`→`S_IDLE` on any write. Data 0x00 also clears the mode.
- `S_ADDR`→`S_BUSY` on any write.
- `S_BUSY`→`S_IDLE` when the timer expires.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The reset input `rst_n` is active low and asynchronous. It clears busy, program request, bypass and secured flags at once. A reset during a program aborts it and leaves the array word unchanged. The array powers up with every bit at 1.
- R2: A standard program is four writes: address 0x555 with data 0xAA, address 0x2AA with data 0x55, address 0x555 with data 0xA0, then the target address and data. The array word index is the low `MEM_AW` address bits.
- R3: A write that does not match the next expected unlock or setup write returns the decoder to read mode, so no program starts from a broken sequence.
- R4: After the address/data write, `busy` is high for exactly `BUSY_CYC` cycles. `pgm_req` is high only in the last of them, when the array is written.
- R5: Every write that arrives while `busy` is high is ignored: it changes no mode and programs nothing.
- R6: A program stores the old word ANDed with the new data, so a bit at 0 never returns to 1.
- R7: The three-write sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0x20 sets `byp_active`.
- R8: In bypass mode, a write with data 0xA0 (any address) followed by the address/data write programs the array. The decoder stays in bypass mode afterwards.
- R9: In bypass mode, writes other than 0xA0 and 0x90 are ignored. This includes unlock and secured-entry sequences.
- R10: Bypass is left by a write with data 0x90 followed by a write with data 0x00. If the second write carries other data, bypass stays active.
- R11: With `accel` high, the decoder in read mode enters bypass mode on the next edge without any unlock writes. A write in that same cycle is ignored. `accel` has no effect while the secured region is selected.
- R12: 0x555/0xAA, 0x2AA/0x55, 0x555/0x88 sets `sec_sel`. While it is set, programs and reads use the secured bank, indexed by the low `SEC_AW` address bits.
- R13: The secured region is left by 0x555/0xAA, 0x2AA/0x55, 0x555/0x90, then a write with data 0x00. While it is selected, the bypass entry sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| accel | input | 1 | Accelerate request; forces bypass mode from read mode |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 11 | Bus write address |
| wr_data | input | DATA_W | Bus write data / command byte in low 8 bits |
| rd_addr | input | MEM_AW | Array read index |
| rd_data | output | DATA_W | Array read data from the bank chosen by `sec_sel` |
| busy | output | 1 | Program in progress |
| pgm_req | output | 1 | One-cycle array write strobe |
| pgm_addr | output | MEM_AW | Latched program index |
| pgm_data | output | DATA_W | Latched program data |
| pgm_sec | output | 1 | Program targets the secured bank |
| sec_sel | output | 1 | Secured region selected |
| byp_active | output | 1 | Bypass mode active |

## Verification
The bench goes after the following corner cases:

- **Broken unlock sequence.** A design that did not fall back to read mode would start a program from a setup write with a wrong address.
- **Commands written during the busy window.** A design that decoded them would enter the secured region or re-trigger programming mid-operation.
- **Bypass-mode filtering and the two-write exit with a wrong confirm byte.** A loose design would leave bypass early, or take an unlock sequence as a command.
- **Accelerate input while the secured region is selected.** If it were honoured, bypass and secured mode would be active together.
- **Reset in the middle of a program.** A design that wrote the array at the start of the busy window would show the new data afterwards.
- **Repeated sweeps over every word, then rewrites with set bits.** These expose a store that overwrites instead of ANDing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int unsigned BUS_AW = 11;

    localparam logic [BUS_AW-1:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [BUS_AW-1:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_A        = 8'hAA;
    localparam logic [7:0] KEY_B        = 8'h55;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_BYP_IN   = 8'h20;
    localparam logic [7:0] CMD_SEC_IN   = 8'h88;
    localparam logic [7:0] CMD_EXIT     = 8'h90;
    localparam logic [7:0] CMD_CONFIRM  = 8'h00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_ADDR,
        S_BUSY,
        S_BYP_EXIT,
        S_SEC_EXIT
    } dec_state_t;

endpackage

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
    parameter int unsigned BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy = (cnt_q != '0);
        done = (cnt_q == CNT_W'(1));
    end

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R4
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned MEM_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accel,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tmr_busy,
    input  logic              tmr_done,
    output logic              tmr_start,
    output logic              pgm_req,
    output logic [MEM_AW-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              pgm_sec,
    output logic              sec_sel,
    output logic              byp_active
);
    dec_state_t        state_q, state_d;
    logic              byp_q, byp_d;
    logic              sec_q, sec_d;
    logic [MEM_AW-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              bank_q, bank_d;

    logic       at_a, at_b;
    logic [7:0] cmd;

    always_comb begin
        at_a = (wr_addr == UNLOCK_ADDR_A);
        at_b = (wr_addr == UNLOCK_ADDR_B);
        cmd  = wr_data[7:0];
    end

    always_comb begin
        state_d   = state_q;
        byp_d     = byp_q;
        sec_d     = sec_q;
        addr_d    = addr_q;
        data_d    = data_q;
        bank_d    = bank_q;
        tmr_start = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accel && !sec_q && !byp_q) begin
                    byp_d = 1'b1;
                end else if (wr_en) begin
                    if (byp_q) begin
                        if (cmd == CMD_PROG) begin
                            state_d = S_ADDR;
                        end else if (cmd == CMD_EXIT) begin
                            state_d = S_BYP_EXIT;
                        end
                    end else if (at_a && cmd == KEY_A) begin
                        state_d = S_UNL1;
                    end
                end
            end
            S_UNL1: begin
                if (wr_en) begin
                    state_d = (at_b && cmd == KEY_B) ? S_UNL2 : S_IDLE;
                end
            end
            S_UNL2: begin
                if (wr_en) begin
                    state_d = S_IDLE;
                    if (at_a) begin
                        if (cmd == CMD_PROG) begin
                            state_d = S_ADDR;
                        end else if (cmd == CMD_BYP_IN) begin
                            if (!sec_q) byp_d = 1'b1;
                        end else if (cmd == CMD_SEC_IN) begin
                            sec_d = 1'b1;
                        end else if (cmd == CMD_EXIT) begin
                            if (sec_q) state_d = S_SEC_EXIT;
                        end
                    end
                end
            end
            S_ADDR: begin
                if (wr_en) begin
                    addr_d    = wr_addr[MEM_AW-1:0];
                    data_d    = wr_data;
                    bank_d    = sec_q;
                    tmr_start = 1'b1;
                    state_d   = S_BUSY;
                end
            end
            S_BUSY: begin
                if (tmr_done) state_d = S_IDLE;
            end
            S_BYP_EXIT: begin
                if (wr_en) begin
                    state_d = S_IDLE;
                    if (cmd == CMD_CONFIRM) byp_d = 1'b0;
                end
            end
            S_SEC_EXIT: begin
                if (wr_en) begin
                    state_d = S_IDLE;
                    if (cmd == CMD_CONFIRM) sec_d = 1'b0;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            byp_q   <= 1'b0;
            sec_q   <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            byp_q   <= byp_d;
            sec_q   <= sec_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            bank_q  <= bank_d;
        end
    end

    always_comb begin
        pgm_req    = (state_q == S_BUSY) && tmr_done;
        pgm_addr   = addr_q;
        pgm_data   = data_q;
        pgm_sec    = bank_q;
        sec_sel    = sec_q;
        byp_active = byp_q;
    end

    // R11
    sec_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q |-> !byp_q);

    // R5
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && wr_en) |=> ($stable(byp_q) && $stable(sec_q)));

    // R4
    busy_state_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY) |-> tmr_busy);

endmodule

// File: rtl/fcd_array_model.sv
module fcd_array_model #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned MEM_AW = 4,
    parameter int unsigned SEC_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_req,
    input  logic [MEM_AW-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              pgm_sec,
    input  logic              sec_sel,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned MAIN_WORDS = 1 << MEM_AW;
    localparam int unsigned SEC_WORDS  = 1 << SEC_AW;

    logic [DATA_W-1:0] main_q [MAIN_WORDS] = '{default: '1};
    logic [DATA_W-1:0] sec_q  [SEC_WORDS]  = '{default: '1};

    always_ff @(posedge clk) begin
        if (pgm_req) begin
            if (pgm_sec) begin
                sec_q[pgm_addr[SEC_AW-1:0]] <= sec_q[pgm_addr[SEC_AW-1:0]] & pgm_data;
            end else begin
                main_q[pgm_addr] <= main_q[pgm_addr] & pgm_data;
            end
        end
    end

    always_comb begin
        rd_data = sec_sel ? sec_q[rd_addr[SEC_AW-1:0]] : main_q[rd_addr];
    end

    // R6
    and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && !pgm_sec) |=>
            ((main_q[$past(pgm_addr)] & ~$past(main_q[pgm_addr])) == '0));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned MEM_AW   = 4,
    parameter int unsigned SEC_AW   = 2,
    parameter int unsigned BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accel,
    input  logic              wr_en,
    input  logic [10:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              pgm_req,
    output logic [MEM_AW-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              pgm_sec,
    output logic              sec_sel,
    output logic              byp_active
);
    logic tmr_start;
    logic tmr_done;

    fcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .done  (tmr_done)
    );

    fcd_seq_fsm #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accel      (accel),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tmr_busy   (busy),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .pgm_req    (pgm_req),
        .pgm_addr   (pgm_addr),
        .pgm_data   (pgm_data),
        .pgm_sec    (pgm_sec),
        .sec_sel    (sec_sel),
        .byp_active (byp_active)
    );

    fcd_array_model #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .SEC_AW(SEC_AW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_req  (pgm_req),
        .pgm_addr (pgm_addr),
        .pgm_data (pgm_data),
        .pgm_sec  (pgm_sec),
        .sec_sel  (sec_sel),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int SW = 2;
    localparam int BC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          accel = 1'b0;
    logic          wr_en = 1'b0;
    logic [10:0]   wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy, pgm_req, pgm_sec, sec_sel, byp_active;
    logic [AW-1:0] pgm_addr;
    logic [DW-1:0] pgm_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [DW-1:0] exp_main [16];
    logic [DW-1:0] exp_sec  [4];

    flash_cmd_decoder #(.DATA_W(DW), .MEM_AW(AW), .SEC_AW(SW), .BUSY_CYC(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .accel(accel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data), .pgm_sec(pgm_sec),
        .sec_sel(sec_sel), .byp_active(byp_active)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Counts busy cycles and the position of the single pgm_req cycle (R4)
    task automatic wait_prog();
        int n = 0;
        int req_at = -1;
        int req_cnt = 0;
        while (busy) begin
            if (pgm_req) begin req_at = n; req_cnt++; end
            n++;
            @(negedge clk);
        end
        chk("R4 busy length", n, BC);
        chk("R4 pgm_req position", req_at, BC - 1);
        chk("R4 pgm_req count", req_cnt, 1);
    endtask

    task automatic unlock();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
    endtask

    task automatic prog_std(input int a, input logic [7:0] d);
        unlock();
        wr(11'h555, 8'hA0);
        wr(11'(a), d);
    endtask

    task automatic prog_byp(input int a, input logic [7:0] d);
        wr(11'h7FF, 8'hA0);
        wr(11'(a), d);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic rd_all(input string req);
        for (int a = 0; a < 16; a++) rd_chk(req, a, int'(exp_main[a]));
    endtask

    initial begin
        for (int a = 0; a < 16; a++) exp_main[a] = 8'hFF;
        for (int a = 0; a < 4; a++)  exp_sec[a]  = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 pgm_req in reset", int'(pgm_req), 0);
        chk("R1 sec_sel in reset", int'(sec_sel), 0);
        chk("R1 byp_active in reset", int'(byp_active), 0);
        rst_n = 1'b1;
        rd_all("R1 erased array");

        // R2 R4 R6: standard program sweep over every word
        for (int a = 0; a < 16; a++) begin
            logic [7:0] d = {4'(a), ~4'(a)};
            prog_std(a, d);
            chk("R2 busy after data write", int'(busy), 1);
            wait_prog();
            exp_main[a] = exp_main[a] & d;
        end
        rd_all("R2 programmed values");

        // R7 bypass entry
        unlock();
        wr(11'h555, 8'h20);
        chk("R7 bypass active", int'(byp_active), 1);

        // R8 R6 bypass program sweep, AND with earlier contents
        for (int a = 0; a < 16; a++) begin
            logic [7:0] d = ~(8'd1 << a[2:0]) | ((a >= 8) ? 8'h0F : 8'h00);
            prog_byp(a, d);
            wait_prog();
            exp_main[a] = exp_main[a] & d;
            chk("R8 stays in bypass", int'(byp_active), 1);
        end
        rd_all("R6 AND semantics");
        // R6 setting bits back to 1 does nothing
        prog_byp(3, 8'hFF);
        wait_prog();
        rd_chk("R6 no bit returns to 1", 3, int'(exp_main[3]));

        // R9 writes other than 0xA0/0x90 ignored in bypass
        unlock();
        wr(11'h555, 8'h88);
        wr(11'h555, 8'h20);
        wr(11'h005, 8'h00);
        chk("R9 no secured entry in bypass", int'(sec_sel), 0);
        chk("R9 bypass kept", int'(byp_active), 1);
        chk("R9 no busy", int'(busy), 0);
        rd_chk("R9 array untouched", 5, int'(exp_main[5]));

        // R10 exit with wrong confirm keeps bypass, then proper exit
        wr(11'h000, 8'h90);
        wr(11'h000, 8'h11);
        chk("R10 wrong confirm keeps bypass", int'(byp_active), 1);
        wr(11'h000, 8'h90);
        wr(11'h000, 8'h00);
        chk("R10 bypass left", int'(byp_active), 0);
        // R10 a bare 0xA0 no longer programs
        wr(11'h555, 8'hA0);
        wr(11'h006, 8'h00);
        chk("R10 bare setup ignored", int'(busy), 0);
        rd_chk("R10 array unchanged", 6, int'(exp_main[6]));

        // R3 broken sequences
        wr(11'h555, 8'hAA);
        wr(11'h2AB, 8'h55);
        wr(11'h555, 8'hA0);
        wr(11'h007, 8'h00);
        chk("R3 wrong unlock address", int'(busy), 0);
        unlock();
        wr(11'h554, 8'hA0);
        wr(11'h007, 8'h00);
        chk("R3 wrong setup address", int'(busy), 0);
        rd_chk("R3 array unchanged", 7, int'(exp_main[7]));
        prog_std(7, 8'h0F);
        wait_prog();
        exp_main[7] = exp_main[7] & 8'h0F;
        rd_chk("R3 full sequence after mismatch", 7, int'(exp_main[7]));

        // R5 writes during busy are ignored
        prog_std(8, 8'hF3);
        exp_main[8] = exp_main[8] & 8'hF3;
        unlock();
        wr(11'h555, 8'h88);
        while (busy) @(negedge clk);
        chk("R5 no secured entry while busy", int'(sec_sel), 0);
        wr(11'h008, 8'h00);
        chk("R5 no program after busy writes", int'(busy), 0);
        rd_chk("R5 only first program applied", 8, int'(exp_main[8]));

        // R11 accel enters bypass directly
        @(negedge clk); accel = 1'b1;
        @(negedge clk);
        chk("R11 accel bypass", int'(byp_active), 1);
        prog_byp(9, 8'h7E);
        wait_prog();
        exp_main[9] = exp_main[9] & 8'h7E;
        rd_chk("R11 accel program", 9, int'(exp_main[9]));
        accel = 1'b0;
        wr(11'h000, 8'h90);
        wr(11'h000, 8'h00);
        chk("R11 accel bypass left", int'(byp_active), 0);

        // R12 secured entry and secured-bank programming
        unlock();
        wr(11'h555, 8'h88);
        chk("R12 secured selected", int'(sec_sel), 1);
        for (int a = 0; a < 4; a++) rd_chk("R12 secured bank erased", a, 8'hFF);
        prog_std(2, 8'h3C);
        wait_prog();
        exp_sec[2] = 8'h3C;
        rd_chk("R12 secured word programmed", 2, int'(exp_sec[2]));
        rd_chk("R12 other secured word", 1, int'(exp_sec[1]));
        // R13 bypass entry blocked, R11 accel blocked
        unlock();
        wr(11'h555, 8'h20);
        chk("R13 no bypass in secured", int'(byp_active), 0);
        @(negedge clk); accel = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 accel ignored in secured", int'(byp_active), 0);
        accel = 1'b0;
        // R13 exit
        unlock();
        wr(11'h555, 8'h90);
        wr(11'h000, 8'h00);
        chk("R13 secured left", int'(sec_sel), 0);
        rd_all("R13 main bank intact");

        // R1 reset during program aborts it
        prog_std(10, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 busy cleared by reset", int'(busy), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (BC + 2) @(negedge clk);
        rd_chk("R1 aborted program", 10, int'(exp_main[10]));
        unlock();
        wr(11'h555, 8'h88);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R1 reset clears secured", int'(sec_sel), 0);
        @(negedge clk); rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule